// File: doc/BRIEF.md
# Signal Dispatch Reverse Translation Table

This block is a small, fully associative table that turns the physical address carried by an incoming signal into three things a processor needs to enter a user handler at once: the handler's program counter, the address as the receiving process sees it, and a priority. Each entry covers one page. A lookup keeps the page offset of the incoming physical address and places it under the stored virtual page number.

Software fills the table one entry at a time through a load port. It usually does this on a context switch, when the incoming process has signal handlers defined. A one-cycle invalidate-all empties the table. Each entry's priority is packed into the low bits of its stored virtual tag and is not kept as a separate field. When no entry matches, the lookup returns a fixed default handler PC, passes the physical address through unchanged as the virtual address, and reports priority 0. Priority 0 is the user-mode level.

Top module: `sig_rtlb`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0 and every entry is invalid, so any lookup misses.
- R2: On a hit, `rsp_pc` is the stored handler PC and `rsp_va` is the stored virtual page number joined with bits [11:0] of `lk_pa`.
- R3: On a hit, `rsp_prio` equals the low 2 bits of the `ld_vtag` value that was loaded into the matching entry.
- R4: On a miss, `rsp_hit` is 0, `rsp_pc` is 32'h0000_0180, `rsp_va` equals `lk_pa`, and `rsp_prio` is 0.
- R5: A lookup sampled with `lk_req` high at one clock edge gives `rsp_valid` high for exactly the following cycle. Without a request, `rsp_valid` is 0.
- R6: When several valid entries hold the same physical page, the entry with the lowest index supplies the result.
- R7: One cycle of `inval_all` clears every entry, so lookups after it miss.
- R8: When `inval_all` and `ld_en` are high at the same edge, the invalidate wins and the load is discarded.
- R9: A load writes entry `ld_idx` at the clock edge. A lookup sampled at that same edge sees the old contents, and later lookups see the new ones.
- R10: Matching compares only physical page bits [31:12]. The page offset has no effect on hit or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Clear all entries in one cycle |
| ld_en | input | 1 | Write one entry |
| ld_idx | input | 3 | Entry index to write |
| ld_ppn | input | 20 | Physical page number to match |
| ld_vtag | input | 22 | Virtual page number in bits [21:2], priority in bits [1:0] |
| ld_pc | input | 32 | Handler program counter |
| lk_req | input | 1 | Lookup request |
| lk_pa | input | 32 | Physical signal address |
| rsp_valid | output | 1 | Registered result is present |
| rsp_hit | output | 1 | An entry matched |
| rsp_pc | output | 32 | Handler PC or default PC |
| rsp_va | output | 32 | Translated or passed-through address |
| rsp_prio | output | 2 | Priority, 0 on a miss |

## Verification
A corrupted valid bit or page number shows up one cycle after the next lookup to that page. The response then turns into the miss pattern, with the default PC and an untranslated address, or it takes the values of another entry. A fault in the lowest-index selection only shows when two entries share a page, so the tests load duplicates on purpose. Faults in load ordering or invalidate precedence are exposed by issuing a load together with a lookup or with an invalidate in the same cycle, then checking the next responses.

// File: rtl/sig_rtlb_pkg.sv
`timescale 1ns/1ps
package sig_rtlb_pkg;
    parameter int PA_W    = 32;
    parameter int VA_W    = 32;
    parameter int PC_W    = 32;
    parameter int PG_BITS = 12;
    parameter int PRIO_W  = 2;
    parameter int N_ENT   = 8;

    localparam int IDX_W  = $clog2(N_ENT);
    localparam int PPN_W  = PA_W - PG_BITS;
    localparam int VPN_W  = VA_W - PG_BITS;
    localparam int VTAG_W = VPN_W + PRIO_W;

    localparam logic [PC_W-1:0]   MISS_PC   = 32'h0000_0180;
    localparam logic [PRIO_W-1:0] USER_PRIO = '0;

    typedef struct packed {
        logic              vld;
        logic [PPN_W-1:0]  ppn;
        logic [VTAG_W-1:0] vtag;
        logic [PC_W-1:0]   pc;
    } rtlb_ent_t;

    typedef struct packed {
        logic              hit;
        logic [PC_W-1:0]   pc;
        logic [VA_W-1:0]   va;
        logic [PRIO_W-1:0] prio;
    } rtlb_rsp_t;

    function automatic logic [PPN_W-1:0] page_of(input logic [PA_W-1:0] pa);
        return pa[PA_W-1:PG_BITS];
    endfunction

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VTAG_W-1:0] t);
        return t[VTAG_W-1:PRIO_W];
    endfunction

    function automatic logic [PRIO_W-1:0] prio_of(input logic [VTAG_W-1:0] t);
        return t[PRIO_W-1:0];
    endfunction
endpackage

// File: rtl/sig_rtlb_store.sv
`timescale 1ns/1ps
module sig_rtlb_store
    import sig_rtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inval_all,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  rtlb_ent_t        ld_ent,
    output rtlb_ent_t        ent_o [N_ENT]
);
    logic [N_ENT-1:0] vld_vec;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || inval_all) begin
                ent_o[g].vld <= 1'b0;
            end else if (ld_en && ld_idx == IDX_W'(g)) begin
                ent_o[g] <= ld_ent;
            end
        end
        assign vld_vec[g] = ent_o[g].vld;
    end

    // R7: invalidate empties the table on the next cycle
    a_r7_inval_clears: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> (vld_vec == '0));

    // R8: a load alongside an invalidate leaves nothing valid
    a_r8_inval_beats_load: assert property (@(posedge clk) disable iff (rst)
        (inval_all && ld_en) |=> !vld_vec[$past(ld_idx)]);
endmodule

// File: rtl/sig_rtlb_match.sv
`timescale 1ns/1ps
module sig_rtlb_match
    import sig_rtlb_pkg::*;
(
    input  rtlb_ent_t        ent_i [N_ENT],
    input  logic [PA_W-1:0]  pa,
    output logic [N_ENT-1:0] sel,
    output rtlb_rsp_t        rsp
);
    logic [N_ENT-1:0] hit_vec;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = ent_i[g].vld && (ent_i[g].ppn == page_of(pa));
    end

    always_comb begin
        sel     = '0;
        rsp.hit = 1'b0;
        rsp.pc  = MISS_PC;
        rsp.va  = pa;
        rsp.prio = USER_PRIO;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel      = '0;
                sel[i]   = 1'b1;
                rsp.hit  = 1'b1;
                rsp.pc   = ent_i[i].pc;
                rsp.va   = {vpn_of(ent_i[i].vtag), pa[PG_BITS-1:0]};
                rsp.prio = prio_of(ent_i[i].vtag);
            end
        end
    end
endmodule

// File: rtl/sig_rtlb.sv
`timescale 1ns/1ps
module sig_rtlb
    import sig_rtlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inval_all,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [PPN_W-1:0]  ld_ppn,
    input  logic [VTAG_W-1:0] ld_vtag,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic              lk_req,
    input  logic [PA_W-1:0]   lk_pa,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PC_W-1:0]   rsp_pc,
    output logic [VA_W-1:0]   rsp_va,
    output logic [PRIO_W-1:0] rsp_prio
);
    rtlb_ent_t        ld_ent;
    rtlb_ent_t        ents [N_ENT];
    logic [N_ENT-1:0] sel;
    rtlb_rsp_t        rsp_c;
    rtlb_rsp_t        rsp_q;

    assign ld_ent = '{vld: 1'b1, ppn: ld_ppn, vtag: ld_vtag, pc: ld_pc};

    sig_rtlb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .inval_all(inval_all),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_ent   (ld_ent),
        .ent_o    (ents)
    );

    sig_rtlb_match u_match (
        .ent_i(ents),
        .pa   (lk_pa),
        .sel  (sel),
        .rsp  (rsp_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) rsp_q <= rsp_c;
        end
    end

    assign rsp_hit  = rsp_q.hit;
    assign rsp_pc   = rsp_q.pc;
    assign rsp_va   = rsp_q.va;
    assign rsp_prio = rsp_q.prio;

    // R5: response strobe follows the request by one cycle
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid);

    // R4: a miss passes the address through with the default PC
    a_r4_miss_default: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !rsp_c.hit) |=>
            (!rsp_hit && rsp_pc == MISS_PC && rsp_va == $past(lk_pa) && rsp_prio == USER_PRIO));

    // R10: page offset always survives translation
    a_r10_offset_kept: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (rsp_va[PG_BITS-1:0] == $past(lk_pa[PG_BITS-1:0])));

    // R6: at most one entry drives the result
    a_r6_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: tb/tb_sig_rtlb.sv
`timescale 1ns/1ps
module tb_sig_rtlb;
    logic        clk = 1'b0;
    logic        rst;
    logic        inval_all, ld_en, lk_req;
    logic [2:0]  ld_idx;
    logic [19:0] ld_ppn;
    logic [21:0] ld_vtag;
    logic [31:0] ld_pc, lk_pa;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_pc, rsp_va;
    logic [1:0]  rsp_prio;

    int checks = 0;
    int fails  = 0;
    localparam logic [31:0] DEF_PC = 32'h0000_0180;

    always #4 clk = ~clk;

    sig_rtlb dut (
        .clk(clk), .rst(rst), .inval_all(inval_all), .ld_en(ld_en),
        .ld_idx(ld_idx), .ld_ppn(ld_ppn), .ld_vtag(ld_vtag), .ld_pc(ld_pc),
        .lk_req(lk_req), .lk_pa(lk_pa), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_pc(rsp_pc), .rsp_va(rsp_va), .rsp_prio(rsp_prio)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] idx, input logic [19:0] ppn,
                        input logic [21:0] vtag, input logic [31:0] pc);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_ppn = ppn; ld_vtag = vtag; ld_pc = pc;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] pa, input logic hit,
                        input logic [31:0] pc, input logic [31:0] va, input logic [1:0] pr);
        @(negedge clk);
        lk_req = 1'b1; lk_pa = pa;
        @(negedge clk);
        lk_req = 1'b0; ld_en = 1'b0; inval_all = 1'b0;
        chk({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({req, " hit"},   {31'd0, rsp_hit},   {31'd0, hit});
        chk({req, " pc"},    rsp_pc, pc);
        chk({req, " va"},    rsp_va, va);
        chk({req, " prio"},  {30'd0, rsp_prio}, {30'd0, pr});
    endtask

    task automatic t_reset;
        chk("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
        look("R1 empty table", 32'h1234_5678, 1'b0, DEF_PC, 32'h1234_5678, 2'd0);
    endtask

    task automatic t_hit;
        load(3'd3, 20'h00042, {20'h70000, 2'd3}, 32'h8000_1000);
        look("R2 R3 hit", 32'h0004_2ABC, 1'b1, 32'h8000_1000, 32'h7000_0ABC, 2'd3);
        look("R10 other offset", 32'h0004_2000, 1'b1, 32'h8000_1000, 32'h7000_0000, 2'd3);
    endtask

    task automatic t_miss;
        look("R4 miss", 32'h0009_9123, 1'b0, DEF_PC, 32'h0009_9123, 2'd0);
        @(negedge clk);
        chk("R5 no request", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_lowest;
        load(3'd6, 20'h00042, {20'h60000, 2'd2}, 32'h8000_6000);
        look("R6 index3 over 6", 32'h0004_2010, 1'b1, 32'h8000_1000, 32'h7000_0010, 2'd3);
        load(3'd1, 20'h00042, {20'h50000, 2'd1}, 32'h8000_2000);
        look("R6 index1 wins", 32'h0004_2010, 1'b1, 32'h8000_2000, 32'h5000_0010, 2'd1);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 3'd1; ld_ppn = 20'h00077;
        ld_vtag = {20'h11111, 2'd2}; ld_pc = 32'h8000_7000;
        lk_req = 1'b1; lk_pa = 32'h0004_2010;
        @(negedge clk);
        ld_en = 1'b0; lk_req = 1'b0;
        chk("R9 old contents hit", {31'd0, rsp_hit}, 32'd1);
        chk("R9 old contents pc", rsp_pc, 32'h8000_2000);
        look("R9 new contents", 32'h0004_2010, 1'b1, 32'h8000_1000, 32'h7000_0010, 2'd3);
        look("R9 reloaded entry", 32'h0007_7004, 1'b1, 32'h8000_7000, 32'h1111_1004, 2'd2);
    endtask

    task automatic t_inval;
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        look("R7 after invalidate", 32'h0007_7004, 1'b0, DEF_PC, 32'h0007_7004, 2'd0);
        look("R7 other page", 32'h0004_2010, 1'b0, DEF_PC, 32'h0004_2010, 2'd0);
        @(negedge clk);
        inval_all = 1'b1; ld_en = 1'b1; ld_idx = 3'd0; ld_ppn = 20'h00011;
        ld_vtag = {20'h22222, 2'd1}; ld_pc = 32'h8000_0011;
        @(negedge clk);
        inval_all = 1'b0; ld_en = 1'b0;
        look("R8 load discarded", 32'h0001_1008, 1'b0, DEF_PC, 32'h0001_1008, 2'd0);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; inval_all = 1'b0; ld_en = 1'b0; lk_req = 1'b0;
        ld_idx = '0; ld_ppn = '0; ld_vtag = '0; ld_pc = '0; lk_pa = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hit();
        t_miss();
        t_lowest();
        t_same_cycle();
        t_inval();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule